// File: doc/BRIEF.md
# Forwarding Database Command Engine

This block manages a small on-chip table of Ethernet MAC addresses that is split into numbered forwarding databases. A host sets up an operation through a few 16-bit registers: a 48-bit MAC address held in three registers, an entry data word, and the database number, which is packed into the operation register together with a 3-bit opcode and a busy flag. Writing the operation register with the busy flag set starts a command. The busy flag stays set while the command runs and clears on its own when the command finishes.

The engine can load or purge one entry. It can return the next valid entry in a database, so repeated calls walk the table in ascending address order. It can also flush entries, or move them between ports, across the whole table or within one database, for either all entries or only non-static ones. The table holds 16 entries and the engine scans it one entry per clock. The state machine has six states: IDLE, LOAD_SCAN, LOAD_COMMIT, NEXT_SCAN, NEXT_DONE and FLUSH_SCAN. Its transitions are:
- IDLE to LOAD_SCAN, NEXT_SCAN or FLUSH_SCAN, according to the opcode written with busy set.
- Each scan state to its successor after the last index: LOAD_COMMIT, NEXT_DONE, or IDLE for a flush.
- LOAD_COMMIT and NEXT_DONE back to IDLE after one cycle.

Top module: `mac_tbl_engine`

## Requirements
- R1: A write of the operation register (address 0) with bit 15 set, issued while idle, starts the command held in bits 14:12. The opcodes are 1 load, 2 get-next, 4 flush all, 5 flush non-static, 6 flush all in one database and 7 flush non-static in one database. Bit 15 reads as one while the command runs and clears by itself within ENTRIES+2 cycles.
- R2: The register map places the data word at address 1, the address bytes 0-1, 2-3 and 4-5 at addresses 2, 3 and 4, and the status at address 5. In each address register the earlier byte sits in bits 15:8. The data word carries the state in bits 3:0, the port vector in bits 11:4 and the trunk flag in bit 15.
- R3: A load with a nonzero state stores the entry for that address and database. If such an entry already exists, the load overwrites it.
- R4: A load with state zero removes the matching entry.
- R5: Get-next returns the valid entry of the selected database that has the smallest address strictly above the key. It writes that entry's address and data word back into the registers. A key of all ones starts the search from the lowest address.
- R6: When get-next finds no further entry, the data word reads zero and the address reads all ones.
- R7: The database number's bits 3:0 sit in operation register bits 3:0, and its bits 5:4 sit in bits 9:8. Entries of other databases are neither returned nor changed by a database-limited command.
- R8: A flush with data state zero deletes every entry that matches the command's scope. A data state other than zero or 0xF leaves the table unchanged.
- R9: The non-static variants skip entries whose state is 0xE.
- R10: A flush with data state 0xF moves entries instead of deleting them. The source port number is in data bits 7:4 and the destination port number is in bits 11:8. A matching entry that holds the source port loses it and gains the destination port. A destination of 8 or more only removes the source port, and an entry left with no ports is deleted.
- R11: A load with a nonzero state into a full table with no matching entry leaves the table unchanged and sets status bit 0. That bit stays set until reset.
- R12: Register writes made while busy is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address for both write and read |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for host_addr, combinational |

## Verification
A corrupted scan index or match flag shows up at the ports within one command. A get-next walk then returns an address out of ascending order, an entry from the wrong database, or a missing terminator. A stuck state machine shows up as a busy bit that is still set after ENTRIES+2 cycles. A wrong move or flush decision appears as a changed data word on the next get-next that reaches the entry. A full flag raised when it should not be is visible on the status register as soon as the load ends.

// File: rtl/mtbl_pkg.sv
package mtbl_pkg;
    localparam int MAC_W  = 48;
    localparam int DB_W   = 6;
    localparam int PORTS  = 8;
    localparam int ST_W   = 4;
    localparam int HALF_W = PORTS / 2;

    localparam logic [ST_W-1:0] ST_NONE   = 4'h0;
    localparam logic [ST_W-1:0] ST_STATIC = 4'hE;
    localparam logic [ST_W-1:0] ST_MOVE   = 4'hF;

    localparam logic [2:0] OPC_LOAD = 3'd1;
    localparam logic [2:0] OPC_NEXT = 3'd2;

    localparam logic [2:0] RA_OP   = 3'd0;
    localparam logic [2:0] RA_DATA = 3'd1;
    localparam logic [2:0] RA_MACH = 3'd2;
    localparam logic [2:0] RA_MACM = 3'd3;
    localparam logic [2:0] RA_MACL = 3'd4;
    localparam logic [2:0] RA_STAT = 3'd5;

    typedef struct packed {
        logic [ST_W-1:0]  st;
        logic             trunk;
        logic [PORTS-1:0] pvec;
        logic [DB_W-1:0]  db;
        logic [MAC_W-1:0] mac;
    } ent_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD_SCAN,
        S_LOAD_COMMIT,
        S_NEXT_SCAN,
        S_NEXT_DONE,
        S_FLUSH_SCAN
    } fsm_e;
endpackage

// File: rtl/mtbl_store.sv
module mtbl_store
    import mtbl_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  ent_t             wentry,
    input  logic [IDX_W-1:0] ridx,
    output ent_t             rentry
);
    ent_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wentry;
        end
    end

    assign rentry = mem[ridx];
endmodule

// File: rtl/mtbl_cmp.sv
module mtbl_cmp
    import mtbl_pkg::*;
(
    input  ent_t             ent,
    input  logic [MAC_W-1:0] key_mac,
    input  logic [DB_W-1:0]  key_db,
    output logic             valid,
    output logic             db_eq,
    output logic             mac_eq,
    output logic             mac_after,
    output logic             is_static
);
    always_comb begin
        valid     = (ent.st != ST_NONE);
        db_eq     = (ent.db == key_db);
        mac_eq    = (ent.mac == key_mac);
        mac_after = (&key_mac) || (ent.mac > key_mac);
        is_static = (ent.st == ST_STATIC);
    end
endmodule

// File: rtl/mtbl_flush.sv
module mtbl_flush
    import mtbl_pkg::*;
(
    input  ent_t             ent,
    input  logic             sel,
    input  logic [ST_W-1:0]  cmd_st,
    input  logic [PORTS-1:0] cmd_pvec,
    output logic             upd,
    output ent_t             nxt
);
    localparam int PIDX_W = $clog2(PORTS);
    localparam logic [HALF_W-1:0] PORT_LIM = HALF_W'(PORTS);

    logic [HALF_W-1:0] src;
    logic [HALF_W-1:0] dst;

    always_comb begin
        src = cmd_pvec[HALF_W-1:0];
        dst = cmd_pvec[PORTS-1:HALF_W];
        nxt = ent;
        upd = 1'b0;
        if (sel) begin
            if (cmd_st == ST_NONE) begin
                upd    = 1'b1;
                nxt    = '0;
            end else if (cmd_st == ST_MOVE && src < PORT_LIM
                         && ent.pvec[src[PIDX_W-1:0]]) begin
                upd = 1'b1;
                nxt.pvec[src[PIDX_W-1:0]] = 1'b0;
                if (dst < PORT_LIM) nxt.pvec[dst[PIDX_W-1:0]] = 1'b1;
                if (nxt.pvec == '0) nxt = '0;
            end
        end
    end
endmodule

// File: rtl/mac_tbl_engine.sv
module mac_tbl_engine
    import mtbl_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);
    fsm_e             st_q, st_d;
    logic [IDX_W-1:0] idx_q;
    logic [MAC_W-1:0] mac_r;
    logic [15:0]      data_r;
    logic [2:0]       opc_r;
    logic [DB_W-1:0]  db_r;
    logic             full_r;
    logic             hit_q, free_q, fnd_q;
    logic [IDX_W-1:0] hit_idx_q, free_idx_q;
    logic [MAC_W-1:0] best_mac_q;
    logic [15:0]      best_data_q;

    logic             busy, op_go, last;
    ent_t             rent, new_ent, fl_nxt, tbl_went;
    logic             tbl_we, fl_upd, fl_sel;
    logic [IDX_W-1:0] tbl_widx;
    logic             c_valid, c_db_eq, c_mac_eq, c_after, c_static;

    assign busy  = (st_q != S_IDLE);
    assign op_go = host_we && host_addr == RA_OP && host_wdata[15] && !busy;
    assign last  = (idx_q == IDX_W'(ENTRIES - 1));

    mtbl_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_widx),
        .wentry(tbl_went), .ridx(idx_q), .rentry(rent)
    );

    mtbl_cmp u_cmp (
        .ent(rent), .key_mac(mac_r), .key_db(db_r), .valid(c_valid),
        .db_eq(c_db_eq), .mac_eq(c_mac_eq), .mac_after(c_after),
        .is_static(c_static)
    );

    assign fl_sel = c_valid && (!opc_r[1] || c_db_eq) && (!opc_r[0] || !c_static);

    mtbl_flush u_flush (
        .ent(rent), .sel(fl_sel), .cmd_st(data_r[3:0]),
        .cmd_pvec(data_r[11:4]), .upd(fl_upd), .nxt(fl_nxt)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (op_go) begin
                    if (host_wdata[14:12] == OPC_LOAD)      st_d = S_LOAD_SCAN;
                    else if (host_wdata[14:12] == OPC_NEXT) st_d = S_NEXT_SCAN;
                    else if (host_wdata[14])                st_d = S_FLUSH_SCAN;
                end
            end
            S_LOAD_SCAN:   if (last) st_d = S_LOAD_COMMIT;
            S_LOAD_COMMIT: st_d = S_IDLE;
            S_NEXT_SCAN:   if (last) st_d = S_NEXT_DONE;
            S_NEXT_DONE:   st_d = S_IDLE;
            S_FLUSH_SCAN:  if (last) st_d = S_IDLE;
            default:       st_d = S_IDLE;
        endcase
    end

    // state and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            idx_q       <= '0;
            mac_r       <= '0;
            data_r      <= '0;
            opc_r       <= '0;
            db_r        <= '0;
            full_r      <= 1'b0;
            hit_q       <= 1'b0;
            free_q      <= 1'b0;
            fnd_q       <= 1'b0;
            hit_idx_q   <= '0;
            free_idx_q  <= '0;
            best_mac_q  <= '0;
            best_data_q <= '0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                S_IDLE: begin
                    idx_q <= '0;
                    if (host_we) begin
                        unique case (host_addr)
                            RA_OP: begin
                                opc_r <= host_wdata[14:12];
                                db_r  <= {host_wdata[9:8], host_wdata[3:0]};
                            end
                            RA_DATA: data_r         <= host_wdata;
                            RA_MACH: mac_r[47:32]   <= host_wdata;
                            RA_MACM: mac_r[31:16]   <= host_wdata;
                            RA_MACL: mac_r[15:0]    <= host_wdata;
                            default: ;
                        endcase
                    end
                    if (op_go) begin
                        hit_q  <= 1'b0;
                        free_q <= 1'b0;
                        fnd_q  <= 1'b0;
                    end
                end
                S_LOAD_SCAN: begin
                    idx_q <= idx_q + 1'b1;
                    if (c_valid && c_db_eq && c_mac_eq) begin
                        hit_q     <= 1'b1;
                        hit_idx_q <= idx_q;
                    end
                    if (!c_valid && !free_q) begin
                        free_q     <= 1'b1;
                        free_idx_q <= idx_q;
                    end
                end
                S_LOAD_COMMIT: begin
                    if (!hit_q && !free_q && data_r[3:0] != ST_NONE) full_r <= 1'b1;
                end
                S_NEXT_SCAN: begin
                    idx_q <= idx_q + 1'b1;
                    if (c_valid && c_db_eq && c_after
                        && (!fnd_q || rent.mac < best_mac_q)) begin
                        fnd_q       <= 1'b1;
                        best_mac_q  <= rent.mac;
                        best_data_q <= {rent.trunk, 3'b000, rent.pvec, rent.st};
                    end
                end
                S_NEXT_DONE: begin
                    mac_r  <= fnd_q ? best_mac_q : '1;
                    data_r <= fnd_q ? best_data_q : '0;
                end
                S_FLUSH_SCAN: idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs: table write port and host read mux
    always_comb begin
        new_ent = '{st: data_r[3:0], trunk: data_r[15], pvec: data_r[11:4],
                    db: db_r, mac: mac_r};
        if (data_r[3:0] == ST_NONE) new_ent = '0;
        tbl_we   = 1'b0;
        tbl_widx = idx_q;
        tbl_went = rent;
        unique case (st_q)
            S_FLUSH_SCAN: begin
                tbl_we   = fl_upd;
                tbl_went = fl_nxt;
            end
            S_LOAD_COMMIT: begin
                tbl_went = new_ent;
                if (hit_q) begin
                    tbl_we   = 1'b1;
                    tbl_widx = hit_idx_q;
                end else if (free_q && data_r[3:0] != ST_NONE) begin
                    tbl_we   = 1'b1;
                    tbl_widx = free_idx_q;
                end
            end
            default: ;
        endcase

        unique case (host_addr)
            RA_OP:   host_rdata = {busy, opc_r, 2'b00, db_r[5:4], 4'h0, db_r[3:0]};
            RA_DATA: host_rdata = data_r;
            RA_MACH: host_rdata = mac_r[47:32];
            RA_MACM: host_rdata = mac_r[31:16];
            RA_MACL: host_rdata = mac_r[15:0];
            RA_STAT: host_rdata = {15'h0000, full_r};
            default: host_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/mtbl_chk.sv
module mtbl_chk
    import mtbl_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic [2:0]  host_addr,
    input logic [15:0] host_wdata,
    input logic        busy,
    input logic        next_done,
    input logic [15:0] mac_hi,
    input logic [15:0] data_q,
    input logic        full,
    input logic        tbl_we
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == RA_OP && host_wdata[15]
         && host_wdata[14:12] != 3'd0 && host_wdata[14:12] != 3'd3 && !busy) |=> busy);

    p_busy_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= 8'(ENTRIES + 1)));

    p_mac_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !next_done && host_we && host_addr == RA_MACH) |=> $stable(mac_hi));

    p_data_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !next_done && host_we && host_addr == RA_DATA) |=> $stable(data_q));

    p_full_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full);

    p_idle_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tbl_we);
endmodule

bind mac_tbl_engine mtbl_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .busy(busy), .next_done(st_q == S_NEXT_DONE),
    .mac_hi(mac_r[47:32]), .data_q(data_r), .full(full_r), .tbl_we(tbl_we)
);

// File: tb/tb_mac_tbl_engine.sv
`timescale 1ns/1ps
module tb_mac_tbl_engine;
    localparam logic [2:0] A_OP = 3'd0, A_DATA = 3'd1, A_MH = 3'd2,
                           A_MM = 3'd3, A_ML = 3'd4, A_ST = 3'd5;
    localparam logic [2:0] C_LOAD = 3'd1, C_NEXT = 3'd2, C_FALL = 3'd4,
                           C_FDYN = 3'd5, C_FALLDB = 3'd6, C_FDYNDB = 3'd7;
    localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mac_tbl_engine dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic start_op(input logic [2:0] opc, input logic [5:0] db);
        wr(A_OP, {1'b1, opc, 2'b00, db[5:4], 4'h0, db[3:0]});
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        v = 16'h8000;
        for (int i = 0; i < 40 && v[15]; i++) rd(A_OP, v);
        chk("R1 busy self-clear", {47'h0, v[15]}, 48'h0);
    endtask

    task automatic set_mac(input logic [47:0] m);
        wr(A_MH, m[47:32]); wr(A_MM, m[31:16]); wr(A_ML, m[15:0]);
    endtask

    task automatic load(input logic [5:0] db, input logic [47:0] m, input logic [15:0] d);
        set_mac(m); wr(A_DATA, d); start_op(C_LOAD, db); wait_idle();
    endtask

    task automatic flush(input logic [2:0] opc, input logic [5:0] db, input logic [15:0] d);
        wr(A_DATA, d); start_op(opc, db); wait_idle();
    endtask

    task automatic next_chk(input string req, input logic [5:0] db, input logic [47:0] key,
                            input logic [47:0] emac, input logic [15:0] edata);
        logic [15:0] h, m, l, d;
        set_mac(key); start_op(C_NEXT, db); wait_idle();
        rd(A_MH, h); rd(A_MM, m); rd(A_ML, l); rd(A_DATA, d);
        chk(req, {h, m, l}, emac);
        chk(req, {32'h0, d}, {32'h0, edata});
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(A_OP, v);   chk("R1 reset op reg", {32'h0, v}, 48'h0);
        rd(A_ST, v);   chk("R11 reset status", {32'h0, v}, 48'h0);
        rd(A_DATA, v); chk("R2 reset data", {32'h0, v}, 48'h0);
        next_chk("R6 empty table", 6'd0, ONES, ONES, 16'h0000);
    endtask

    task automatic t_walk();
        logic [15:0] v;
        load(6'd5, 48'h0011_2233_4455, 16'h0037);
        load(6'd5, 48'h0011_2233_4410, 16'h8047);
        load(6'd5, 48'hAABB_CC00_0001, 16'h00FE);
        start_op(C_NEXT, 6'd5);
        rd(A_OP, v); chk("R1 busy during op", {47'h0, v[15]}, 48'h1);
        wait_idle();
        next_chk("R5 walk first", 6'd5, ONES, 48'h0011_2233_4410, 16'h8047);
        next_chk("R5 walk second", 6'd5, 48'h0011_2233_4410, 48'h0011_2233_4455, 16'h0037);
        rd(A_MH, v); chk("R2 bytes 0-1", {32'h0, v}, 48'h0011);
        rd(A_ML, v); chk("R2 bytes 4-5", {32'h0, v}, 48'h4455);
        next_chk("R5 walk third", 6'd5, 48'h0011_2233_4455, 48'hAABB_CC00_0001, 16'h00FE);
        next_chk("R6 walk end", 6'd5, 48'hAABB_CC00_0001, ONES, 16'h0000);
    endtask

    task automatic t_db();
        logic [15:0] v;
        load(6'd37, 48'h0011_2233_4420, 16'h0017);
        next_chk("R7 other db hidden", 6'd5, 48'h0011_2233_4410, 48'h0011_2233_4455, 16'h0037);
        next_chk("R7 high db bits", 6'd37, ONES, 48'h0011_2233_4420, 16'h0017);
        rd(A_OP, v); chk("R7 db field readback", {32'h0, v}, 48'h2205);
    endtask

    task automatic t_over_purge();
        load(6'd5, 48'h0011_2233_4455, 16'h0097);
        next_chk("R3 overwrite", 6'd5, 48'h0011_2233_4410, 48'h0011_2233_4455, 16'h0097);
        load(6'd5, 48'h0011_2233_4455, 16'h0000);
        next_chk("R4 purge", 6'd5, 48'h0011_2233_4410, 48'hAABB_CC00_0001, 16'h00FE);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        set_mac(48'h0000_0000_0E00); wr(A_DATA, 16'h0057); start_op(C_LOAD, 6'd5);
        wr(A_DATA, 16'h0000);
        wr(A_ML, 16'hFFFF);
        wait_idle();
        rd(A_DATA, v); chk("R12 data write ignored", {32'h0, v}, 48'h0057);
        rd(A_ML, v);   chk("R12 mac write ignored", {32'h0, v}, 48'h0E00);
        next_chk("R12 load used original", 6'd5, 48'h0, 48'h0000_0000_0E00, 16'h0057);
    endtask

    task automatic t_flush_dyn_db();
        flush(C_FDYNDB, 6'd5, 16'h0000);
        next_chk("R9 static kept", 6'd5, ONES, 48'hAABB_CC00_0001, 16'h00FE);
        next_chk("R8 dynamic gone", 6'd5, 48'hAABB_CC00_0001, ONES, 16'h0000);
        next_chk("R7 other db untouched", 6'd37, ONES, 48'h0011_2233_4420, 16'h0017);
        flush(C_FALL, 6'd0, 16'h0003);
        next_chk("R8 other state no-op", 6'd5, ONES, 48'hAABB_CC00_0001, 16'h00FE);
    endtask

    task automatic t_move();
        load(6'd9, 48'h0200_0000_0001, 16'h0037);
        load(6'd9, 48'h0200_0000_0002, 16'h0027);
        load(6'd9, 48'h0200_0000_0003, 16'h001E);
        flush(C_FALLDB, 6'd9, 16'h060F);
        next_chk("R10 move port0->6", 6'd9, ONES, 48'h0200_0000_0001, 16'h0427);
        next_chk("R10 no source untouched", 6'd9, 48'h0200_0000_0001, 48'h0200_0000_0002, 16'h0027);
        next_chk("R10 static moved by all", 6'd9, 48'h0200_0000_0002, 48'h0200_0000_0003, 16'h040E);
        flush(C_FDYNDB, 6'd9, 16'h0F1F);
        next_chk("R10 remove port", 6'd9, ONES, 48'h0200_0000_0001, 16'h0407);
        next_chk("R10 empty vector deleted", 6'd9, 48'h0200_0000_0001, 48'h0200_0000_0003, 16'h040E);
    endtask

    task automatic t_flush_all();
        flush(C_FALL, 6'd0, 16'h0000);
        next_chk("R8 flush all db5", 6'd5, ONES, ONES, 16'h0000);
        next_chk("R8 flush all db9", 6'd9, ONES, ONES, 16'h0000);
        next_chk("R8 flush all db37", 6'd37, ONES, ONES, 16'h0000);
    endtask

    task automatic t_full();
        logic [15:0] v;
        for (int i = 0; i < 16; i++) load(6'd1, 48'h100 + 48'(i), 16'h0017);
        rd(A_ST, v); chk("R11 not full yet", {32'h0, v}, 48'h0);
        load(6'd1, 48'h200, 16'h0017);
        rd(A_ST, v); chk("R11 full flag", {32'h0, v}, 48'h1);
        next_chk("R11 table unchanged", 6'd1, 48'h10F, ONES, 16'h0000);
        load(6'd1, 48'h105, 16'h0027);
        next_chk("R3 overwrite when full", 6'd1, 48'h104, 48'h105, 16'h0027);
        rd(A_ST, v); chk("R11 sticky", {32'h0, v}, 48'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_walk();
        t_db();
        t_over_purge();
        t_busy_ignore();
        t_flush_dyn_db();
        t_move();
        t_flush_all();
        t_full();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule